// File: doc/BRIEF.md
# Correlator control/status register file

This block is the host-facing register pair of a correlation engine. A processor reaches it through an 8-bit memory-mapped slave port with a chip select, active-low write and read strobes and a single address bit. The control word at address 0 starts the engine, keeps it enabled, holds it in a synchronous soft reset and gates its two interrupt lines. The status word at address 1 reports whether a correlation is running and latches sticky event flags. Those flags, and the finished bit, are consumed by reading the status word.

The engine drives three single-cycle event inputs: correlation finished, result buffer switched (a new set of I/Q lag results is available) and block complete. Each buffer switch and each block completion also produces a one-cycle interrupt pulse, provided its enable bit is set. The engine itself is outside this block.

Top module: `corr_csr`

## Requirements
- R1: After the active-low asynchronous reset, every register is 0: start_pulse, run_enable, soft_abort, irq_result and irq_block are 0 and both words read 0x00.
- R2: A write (cs=1, wr_n=0, addr=0) loads the control word at the clock edge: bit 1 run enable, bit 2 soft abort, bit 3 result interrupt enable, bit 4 block interrupt enable. Bits 7:5 read as 0 whatever was written.
- R3: Writing control bit 0 as 1 makes start_pulse high for the single following cycle, and it reads back as control bit 0 only in that cycle. The start is ignored when the same write sets bit 2 or when soft abort is already set.
- R4: Status bit 0 (active) becomes 1 at the edge that accepts a start and returns to 0 at the edge that samples evt_done.
- R5: Status bit 1 (finished) latches on evt_done, bit 3 on evt_swap and bit 4 on evt_block; status bits 2, 7:5 read as 0.
- R6: A status read (cs=1, rd_n=0, addr=1) clears bits 1, 3 and 4 at the edge that samples it; an event sampled at that same edge keeps its bit set. Bit 0 is not cleared by reading.
- R7: irq_result pulses for one cycle, the cycle after evt_swap is sampled, only when control bit 3 is set; irq_block does the same for evt_block and control bit 4.
- R8: While soft abort is set, status bits 0, 1, 3 and 4 are forced to 0 from the next edge on, events are not latched and neither interrupt pulses.
- R9: rdata is 0xFF whenever cs is 0 or rd_n is 1.
- R10: Writes to address 1 change neither the status word nor the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 1 | 0 selects control, 1 selects status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, all ones when not read |
| evt_done | input | 1 | Engine finished the current correlation |
| evt_swap | input | 1 | Result buffer switched, new lag results ready |
| evt_block | input | 1 | Engine finished a whole block |
| start_pulse | output | 1 | One-cycle start command to the engine |
| run_enable | output | 1 | Engine enable level |
| soft_abort | output | 1 | Soft reset level to the engine |
| irq_result | output | 1 | Result-ready interrupt pulse |
| irq_block | output | 1 | Block-complete interrupt pulse |

## Verification
The collision that matters is a status read landing in the same cycle as an engine event that sets the very flag the read consumes. The bench drives a status read together with evt_swap, evt_done or evt_block in the same cycle, both in a directed case and in random traffic where reads and events are independently frequent. It judges the outcome by the following status read: the flag must still be set, although the coincident read showed it clear. Soft abort set in the same cycle as events is provoked likewise and must leave flags and interrupts silent.

// File: rtl/corr_csr_pkg.sv
package corr_csr_pkg;

   // control word bit positions (software visible)
   localparam int unsigned CTL_START  = 0;
   localparam int unsigned CTL_ENABLE = 1;
   localparam int unsigned CTL_ABORT  = 2;
   localparam int unsigned CTL_RES_IE = 3;
   localparam int unsigned CTL_BLK_IE = 4;

   // status word bit positions (software visible)
   localparam int unsigned ST_ACTIVE   = 0;
   localparam int unsigned ST_DONE     = 1;
   localparam int unsigned ST_RES_FLAG = 3;
   localparam int unsigned ST_BLK_FLAG = 4;

   localparam int unsigned CSR_MIN_W = 5;

   // sticky flag slots, also interrupt slots for the last two
   localparam int unsigned N_STICKY  = 3;
   localparam int unsigned SL_DONE   = 0;
   localparam int unsigned SL_RES    = 1;
   localparam int unsigned SL_BLK    = 2;

   localparam int unsigned N_IRQ     = 2;
   localparam int unsigned IQ_RES    = 0;
   localparam int unsigned IQ_BLK    = 1;

   typedef struct packed {
      logic blk_ie;
      logic res_ie;
      logic abort;
      logic enable;
   } ctl_t;

endpackage

// File: rtl/corr_csr_ctrl.sv
module corr_csr_ctrl
   import corr_csr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [DATA_W-1:0] wdata,
   output ctl_t              ctl,
   output logic              start_cmd,
   output logic              start_q
);

   // a start is accepted only outside soft abort, old or newly written
   always_comb begin
      start_cmd = wr_ctl && wdata[CTL_START] && !wdata[CTL_ABORT] && !ctl.abort;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= start_cmd;
         if (wr_ctl) begin
            ctl.enable <= wdata[CTL_ENABLE];
            ctl.abort  <= wdata[CTL_ABORT];
            ctl.res_ie <= wdata[CTL_RES_IE];
            ctl.blk_ie <= wdata[CTL_BLK_IE];
         end
      end
   end

endmodule

// File: rtl/corr_csr_sticky.sv
module corr_csr_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_clr,
   input  logic set,
   input  logic rd_clr,
   output logic q
);

   // soft clear dominates, a new event beats the read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (soft_clr) q <= 1'b0;
      else if (set)      q <= 1'b1;
      else if (rd_clr)   q <= 1'b0;
   end

endmodule

// File: rtl/corr_csr_flags.sv
module corr_csr_flags
   import corr_csr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_clr,
   input  logic                start_cmd,
   input  logic                rd_sts,
   input  logic [N_STICKY-1:0] evt,
   output logic                active,
   output logic [N_STICKY-1:0] sticky
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 active <= 1'b0;
      else if (soft_clr)          active <= 1'b0;
      else if (start_cmd)         active <= 1'b1;
      else if (evt[SL_DONE])      active <= 1'b0;
   end

   for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
      corr_csr_sticky u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_clr),
         .set      (evt[g]),
         .rd_clr   (rd_sts),
         .q        (sticky[g])
      );
   end

endmodule

// File: rtl/corr_csr_irq.sv
module corr_csr_irq #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic en,
   input  logic quiet,
   output logic irq
);

   logic fire;

   always_comb begin
      fire = evt && en && !quiet;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= fire;
      end
   end else begin : g_comb
      logic unused_clk;
      always_comb begin
         unused_clk = clk ^ rst_n;
         irq        = fire;
      end
   end

endmodule

// File: rtl/corr_csr.sv
module corr_csr
   import corr_csr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          IRQ_OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              evt_done,
   input  logic              evt_swap,
   input  logic              evt_block,
   output logic              start_pulse,
   output logic              run_enable,
   output logic              soft_abort,
   output logic              irq_result,
   output logic              irq_block
);

   if (DATA_W < CSR_MIN_W) begin : g_width_bad
      $error("corr_csr: DATA_W must hold the highest defined bit");
   end

   logic                wr_ctl;
   logic                rd_sts;
   logic                rd_any;
   ctl_t                ctl_q;
   logic                start_cmd;
   logic                start_q;
   logic                active;
   logic [N_STICKY-1:0] evt_vec;
   logic [N_STICKY-1:0] sticky;
   logic                done_flag;
   logic [N_IRQ-1:0]    irq_evt;
   logic [N_IRQ-1:0]    irq_en;
   logic [N_IRQ-1:0]    irq_vec;
   logic [DATA_W-1:0]   ctl_word;
   logic [DATA_W-1:0]   sts_word;

   always_comb begin
      rd_any = cs && !rd_n;
      wr_ctl = cs && !wr_n && !addr;
      rd_sts = rd_any && addr;
      evt_vec[SL_DONE] = evt_done;
      evt_vec[SL_RES]  = evt_swap;
      evt_vec[SL_BLK]  = evt_block;
      irq_evt[IQ_RES]  = evt_swap;
      irq_evt[IQ_BLK]  = evt_block;
      irq_en[IQ_RES]   = ctl_q.res_ie;
      irq_en[IQ_BLK]   = ctl_q.blk_ie;
   end

   corr_csr_ctrl #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (wr_ctl),
      .wdata     (wdata),
      .ctl       (ctl_q),
      .start_cmd (start_cmd),
      .start_q   (start_q)
   );

   corr_csr_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (ctl_q.abort),
      .start_cmd (start_cmd),
      .rd_sts    (rd_sts),
      .evt       (evt_vec),
      .active    (active),
      .sticky    (sticky)
   );

   for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
      corr_csr_irq #(
         .OUT_REG (IRQ_OUT_REG)
      ) u_irq (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (irq_evt[g]),
         .en    (irq_en[g]),
         .quiet (ctl_q.abort),
         .irq   (irq_vec[g])
      );
   end

   assign done_flag = sticky[SL_DONE];

   always_comb begin
      ctl_word             = '0;
      ctl_word[CTL_START]  = start_q;
      ctl_word[CTL_ENABLE] = ctl_q.enable;
      ctl_word[CTL_ABORT]  = ctl_q.abort;
      ctl_word[CTL_RES_IE] = ctl_q.res_ie;
      ctl_word[CTL_BLK_IE] = ctl_q.blk_ie;

      sts_word              = '0;
      sts_word[ST_ACTIVE]   = active;
      sts_word[ST_DONE]     = done_flag;
      sts_word[ST_RES_FLAG] = sticky[SL_RES];
      sts_word[ST_BLK_FLAG] = sticky[SL_BLK];

      if (rd_any) rdata = addr ? sts_word : ctl_word;
      else        rdata = '1;
   end

   assign start_pulse = start_q;
   assign run_enable  = ctl_q.enable;
   assign soft_abort  = ctl_q.abort;
   assign irq_result  = irq_vec[IQ_RES];
   assign irq_block   = irq_vec[IQ_BLK];

endmodule

// File: rtl/corr_csr_chk.sv
module corr_csr_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter bit          IRQ_OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              wr_n,
   input logic              addr,
   input logic [DATA_W-1:0] wdata,
   input logic              evt_done,
   input logic              evt_swap,
   input logic              evt_block,
   input logic              start_pulse,
   input logic              soft_abort,
   input logic              irq_result,
   input logic              irq_block,
   input logic              sts_done
);

   AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(cs && !wr_n && !addr && wdata[0])); // R3

   AST_START_NOT_IN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> !$past(soft_abort)); // R3

   AST_DONE_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && !soft_abort) |=> sts_done); // R6

   if (IRQ_OUT_REG) begin : g_reg_chk
      AST_RES_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_result |-> $past(evt_swap)); // R7

      AST_BLK_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_block |-> $past(evt_block)); // R7

      AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         soft_abort |=> (!irq_result && !irq_block)); // R8
   end else begin : g_comb_chk
      AST_RES_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_result |-> evt_swap); // R7

      AST_BLK_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_block |-> evt_block); // R7
   end

endmodule

bind corr_csr corr_csr_chk #(
   .DATA_W      (DATA_W),
   .IRQ_OUT_REG (IRQ_OUT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs          (cs),
   .wr_n        (wr_n),
   .addr        (addr),
   .wdata       (wdata),
   .evt_done    (evt_done),
   .evt_swap    (evt_swap),
   .evt_block   (evt_block),
   .start_pulse (start_pulse),
   .soft_abort  (soft_abort),
   .irq_result  (irq_result),
   .irq_block   (irq_block),
   .sts_done    (done_flag)
);

// File: tb/corr_csr_test.sv
module corr_csr_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       evt_done = 1'b0, evt_swap = 1'b0, evt_block = 1'b0;
   logic       start_pulse, run_enable, soft_abort, irq_result, irq_block;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // bench model of the register state
   logic m_en, m_ab, m_rie, m_bie, m_st, m_act, m_fin, m_fr, m_fb, m_ir, m_ib;

   always #5 clk = ~clk;

   corr_csr uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_done(evt_done), .evt_swap(evt_swap),
      .evt_block(evt_block), .start_pulse(start_pulse), .run_enable(run_enable),
      .soft_abort(soft_abort), .irq_result(irq_result), .irq_block(irq_block)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic c, input logic r, input logic a);
      if (!(c && !r)) return 8'hFF;
      if (a) return {3'b000, m_fb, m_fr, 1'b0, m_fin, m_act};
      return {3'b000, m_bie, m_rie, m_ab, m_en, m_st};
   endfunction

   task automatic model_reset();
      {m_en, m_ab, m_rie, m_bie, m_st, m_act, m_fin, m_fr, m_fb, m_ir, m_ib} = '0;
   endtask

   task automatic model_step(input logic c, w, r, a, input logic [7:0] d,
                             input logic dn, sw, bk);
      logic wr0, rd1, sc;
      wr0 = c && !w && !a;
      rd1 = c && !r && a;
      sc  = wr0 && d[0] && !d[2] && !m_ab;
      m_ir = sw && m_rie && !m_ab;
      m_ib = bk && m_bie && !m_ab;
      if (m_ab) begin
         {m_act, m_fin, m_fr, m_fb} = '0;
      end else begin
         m_act = sc ? 1'b1 : (dn ? 1'b0 : m_act);
         m_fin = dn ? 1'b1 : (rd1 ? 1'b0 : m_fin);
         m_fr  = sw ? 1'b1 : (rd1 ? 1'b0 : m_fr);
         m_fb  = bk ? 1'b1 : (rd1 ? 1'b0 : m_fb);
      end
      m_st = sc;
      if (wr0) begin
         m_en = d[1]; m_ab = d[2]; m_rie = d[3]; m_bie = d[4];
      end
   endtask

   // one bus cycle: entered and left at a falling edge
   task automatic cyc(input logic c, w, r, a, input logic [7:0] d,
                      input logic dn, sw, bk, output logic [7:0] got);
      string tg;
      cs = c; wr_n = w; rd_n = r; addr = a; wdata = d;
      evt_done = dn; evt_swap = sw; evt_block = bk;
      #1;
      got = rdata;
      tg = !(c && !r) ? "R9" : (a ? "R5" : "R2");
      chk(tg, rdata, exp_rd(c, r, a));
      @(posedge clk);
      model_step(c, w, r, a, d, dn, sw, bk);
      @(negedge clk);
      chk("R3", {7'd0, start_pulse}, {7'd0, m_st});
      chk("R2", {7'd0, run_enable},  {7'd0, m_en});
      chk("R8", {7'd0, soft_abort},  {7'd0, m_ab});
      chk("R7", {7'd0, irq_result},  {7'd0, m_ir});
      chk("R7", {7'd0, irq_block},   {7'd0, m_ib});
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      logic [7:0] g;
      cyc(1, 0, 1, a, d, 0, 0, 0, g);
   endtask

   task automatic rd(input logic a, output logic [7:0] g);
      cyc(1, 1, 0, a, 8'h00, 0, 0, 0, g);
   endtask

   task automatic ev(input logic dn, sw, bk);
      logic [7:0] g;
      cyc(0, 1, 1, 0, 8'h00, dn, sw, bk, g);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] g;
      int unsigned seed_v;
      seed_v = $urandom(32'h0C0FFEE5);
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {3'd0, start_pulse, run_enable, soft_abort, irq_result, irq_block}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(0, g); chk("R1", g, 8'h00);
      rd(1, g); chk("R1", g, 8'h00);

      // R2: control write and readback, reserved bits
      wr(0, 8'h1A); rd(0, g); chk("R2", g, 8'h1A);
      wr(0, 8'hFA); rd(0, g); chk("R2", g, 8'h1A);

      // R3/R4: start pulse and active
      wr(0, 8'h1B);
      chk("R3", {7'd0, start_pulse}, 8'h01);
      ev(0, 0, 0);
      chk("R3", {7'd0, start_pulse}, 8'h00);
      rd(1, g); chk("R4", g, 8'h01);
      ev(1, 0, 0);
      rd(1, g); chk("R4", g, 8'h02);
      rd(1, g); chk("R6", g, 8'h00);

      // R6: event coincident with status read survives
      cyc(1, 1, 0, 1, 8'h00, 0, 1, 0, g);
      chk("R7", {7'd0, irq_result}, 8'h01);
      rd(1, g); chk("R6", g, 8'h08);
      cyc(1, 1, 0, 1, 8'h00, 1, 0, 1, g);
      rd(1, g); chk("R6", g, 8'h12);

      // R7: interrupts gated off
      wr(0, 8'h02);
      ev(0, 1, 1);
      chk("R7", {6'd0, irq_result, irq_block}, 8'h00);
      ev(1, 0, 0);

      // R8: abort clears status, start ignored, events dropped
      wr(0, 8'h1F);
      chk("R3", {7'd0, start_pulse}, 8'h00);
      ev(0, 0, 0);
      rd(1, g); chk("R8", g, 8'h00);
      ev(1, 1, 1);
      chk("R8", {6'd0, irq_result, irq_block}, 8'h00);
      rd(1, g); chk("R8", g, 8'h00);
      wr(0, 8'h13);
      chk("R3", {7'd0, start_pulse}, 8'h00);
      wr(0, 8'h02);

      // R10: writes to the status address are ignored
      wr(0, 8'h03);
      rd(1, g); chk("R4", g, 8'h01);
      wr(1, 8'hFF);
      rd(1, g); chk("R10", g, 8'h01);
      rd(0, g); chk("R10", g, 8'h02);

      // R9: unselected or idle reads
      cyc(0, 1, 0, 1, 8'h00, 0, 0, 0, g); chk("R9", g, 8'hFF);
      cyc(1, 1, 1, 0, 8'h00, 0, 0, 0, g); chk("R9", g, 8'hFF);

      // constrained random traffic, checked against the model each cycle
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         if ($urandom_range(7) != 0) d[2] = 1'b0;
         cyc($urandom_range(3) != 0, 1'($urandom), 1'($urandom), 1'($urandom), d,
             $urandom_range(3) == 0, $urandom_range(3) == 0, $urandom_range(3) == 0, g);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule